// File: doc/BRIEF.md
# Tagged Word-to-Byte Unpacker

The unpacker takes 32-bit packed words, each with a 4-bit channel tag, from the pop side of a receive FIFO. It works out how many bytes each word carries from the filler values in its upper lanes, then sends those bytes out one at a time. Bytes leave on a valid/ready byte port, lowest lane first. Each byte carries the tag of the word it came from and a flag that marks the final byte of that word.

The filler tests run from the shortest form to the longest. A word with a filler value in all three upper lanes carries one byte. Failing that, a word with filler values in the top two lanes carries two bytes. Failing that, a word with a filler value in the top lane carries three bytes. Any other word carries four bytes. An optional filter lets the block serve a single channel of a shared stream: when the filter is on, words tagged for any other channel are popped and dropped, and they produce no output.

Top module: `unpk_tagged_unpacker`

## Requirements
- R1: A word whose bits 31:8 equal 0x808080 yields exactly one byte, bits 7:0, with the last flag set.
- R2: A word that fails the R1 test and whose bits 31:16 equal 0x8181 yields two bytes: bits 7:0, then bits 15:8.
- R3: A word that fails the R1 and R2 tests and whose bits 31:24 equal 0x82 yields three bytes: bits 7:0, 15:8, 23:16.
- R4: Every other word yields four bytes: bits 7:0, 15:8, 23:16, 31:24.
- R5: Across a stream of words, the byte sequence that leaves the block equals the concatenation of each word's bytes, in word order.
- R6: Each output byte carries the channel tag of its source word on out_tag. out_last is 1 only on the final byte of that word.
- R7: When filt_en is 1, a word whose tag differs from filt_chan is accepted (in_ready high) and produces no output byte.
- R8: When filt_en is 0, words of every tag are delivered.
- R9: in_ready is 0 from the accept of a word until the handshake of its last byte. A word accepted while in_ready is 1 presents its first byte on the next cycle.
- R10: After reset, out_valid is 0 and in_ready is 1.
- R11: While out_valid is 1 and out_ready is 0, out_byte, out_tag and out_last hold their values and out_valid stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Receive FIFO not empty |
| in_word | input | 32 | Packed word at the FIFO head |
| in_tag | input | 4 | Channel tag of the head word |
| in_ready | output | 1 | Pop strobe for the receive FIFO |
| filt_en | input | 1 | Deliver only the channel in filt_chan |
| filt_chan | input | 4 | Channel kept in filter mode |
| out_valid | output | 1 | Byte available |
| out_byte | output | 8 | Current byte |
| out_tag | output | 4 | Channel tag of the current byte |
| out_last | output | 1 | Final byte of its word |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
A word accepted on a rising edge shows its first byte straight after that edge. Each later byte appears after the edge that completes the handshake of the byte before it. in_ready rises again after the edge that takes the last byte, so a back-to-back word costs one idle cycle. The bench drives its inputs and samples the outputs 1 ns after the falling edge, so every value it reads has settled from the preceding rising edge. It records a byte only when valid and ready are both high at that point, which is exactly the handshake the next rising edge completes. Expected streams come from a packer in the bench that applies the filler rules, including the fallback from four bytes to three.

// File: rtl/unpk_pkg.sv
// Shared constants for the tagged unpacker: lane geometry and filler values.
// Assumes four 8-bit lanes per packed word.
package unpk_pkg;
    localparam int LANE_W     = 8;
    localparam int LANES      = 4;
    localparam int WORD_W     = LANE_W * LANES;
    localparam int IDX_W      = $clog2(LANES);
    localparam logic [7:0] FILL_ONE   = 8'h80;
    localparam logic [7:0] FILL_TWO   = 8'h81;
    localparam logic [7:0] FILL_THREE = 8'h82;
endpackage

// File: rtl/unpk_len_decode.sv
// Works out the index of the last payload lane from the upper-lane fillers.
// Tests run from shortest to longest; a word that matches none carries all lanes.
// Purely combinational; assumes the four-lane layout of unpk_pkg.
module unpk_len_decode
    import unpk_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  last_idx
);
    // Priority test of the filler patterns, one byte first.
    always_comb begin
        if (word[31:8] == {3{FILL_ONE}})
            last_idx = IDX_W'(0);
        else if (word[31:16] == {2{FILL_TWO}})
            last_idx = IDX_W'(1);
        else if (word[31:24] == FILL_THREE)
            last_idx = IDX_W'(2);
        else
            last_idx = IDX_W'(LANES - 1);
    end
endmodule

// File: rtl/unpk_lane_hold.sv
// Holds one packed word and presents its lanes one by one, lowest lane first.
// Assumes load is only raised while hold_valid is low.
module unpk_lane_hold
    import unpk_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [IDX_W-1:0]  ld_last_idx,
    input  logic              take,
    output logic              hold_valid,
    output logic [LANE_W-1:0] hold_byte,
    output logic [TAG_W-1:0]  hold_tag,
    output logic              hold_last
);
    logic [WORD_W-1:0] word_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic              busy_q;

    // Load a new word, or step the lane index on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
            tag_q  <= '0;
            word_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= ld_last_idx;
            tag_q  <= ld_tag;
            word_q <= ld_word;
        end else if (busy_q && take) begin
            if (idx_q == last_q)
                busy_q <= 1'b0;
            else
                idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Lane select and last-byte flag.
    always_comb begin
        hold_valid = busy_q;
        hold_byte  = word_q[idx_q*LANE_W +: LANE_W];
        hold_tag   = tag_q;
        hold_last  = (idx_q == last_q);
    end

    p_stall_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !take) |=> (hold_valid && $stable(hold_byte) &&
                                   $stable(hold_tag) && $stable(hold_last)));
endmodule

// File: rtl/unpk_tagged_unpacker.sv
// Top of the tagged unpacker: pops tagged words from a receive FIFO, drops
// words for other channels in filter mode, and emits the payload bytes.
// Assumes the FIFO holds in_word/in_tag steady while in_valid is high.
module unpk_tagged_unpacker
    import unpk_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              in_ready,
    input  logic              filt_en,
    input  logic [TAG_W-1:0]  filt_chan,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_last,
    input  logic              out_ready
);
    logic             keep;
    logic             load;
    logic [IDX_W-1:0] dec_last;

    unpk_len_decode u_dec (
        .word     (in_word),
        .last_idx (dec_last)
    );

    // Accept only when idle; in filter mode load only the chosen channel.
    always_comb begin
        in_ready = !out_valid;
        keep     = !filt_en || (in_tag == filt_chan);
        load     = in_valid && in_ready && keep;
    end

    unpk_lane_hold #(.TAG_W(TAG_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .ld_word     (in_word),
        .ld_tag      (in_tag),
        .ld_last_idx (dec_last),
        .take        (out_ready),
        .hold_valid  (out_valid),
        .hold_byte   (out_byte),
        .hold_tag    (out_tag),
        .hold_last   (out_last)
    );

    p_one_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (!filt_en || in_tag == filt_chan) &&
         in_word[31:8] == 24'h808080) |=> (out_valid && out_last));

    p_filter_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && filt_en && in_tag != filt_chan) |=> !out_valid);

    p_last_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    p_accept_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !filt_en) |=> (out_valid && $stable(filt_en) |-> out_tag == $past(in_tag)));
endmodule

// File: tb/unpk_tagged_unpacker_tb.sv
`timescale 1ns/1ps
module unpk_tagged_unpacker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [3:0]  in_tag = '0;
    logic        in_ready;
    logic        filt_en = 1'b0;
    logic [3:0]  filt_chan = '0;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic [3:0]  out_tag;
    logic        out_last;
    logic        out_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rdy_mode = 0;

    logic [7:0] exp_b[$];
    logic [3:0] exp_t[$];
    logic       exp_l[$];
    logic [7:0] got_b[$];
    logic [3:0] got_t[$];
    logic       got_l[$];

    always #2 clk = ~clk;

    unpk_tagged_unpacker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_tag(in_tag), .in_ready(in_ready), .filt_en(filt_en),
        .filt_chan(filt_chan), .out_valid(out_valid), .out_byte(out_byte),
        .out_tag(out_tag), .out_last(out_last), .out_ready(out_ready)
    );

    // Consumer: set ready per mode, record handshakes due at the next edge.
    always @(negedge clk) begin
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ~out_ready;
            default: out_ready = 1'b0;
        endcase
        #1;
        if (rst_n && out_valid && out_ready) begin
            got_b.push_back(out_byte);
            got_t.push_back(out_tag);
            got_l.push_back(out_last);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
        end
    endtask

    task automatic push_word(input logic [31:0] w, input logic [3:0] t);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_tag = t;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Bench packer: applies the filler rules with the four-to-three fallback.
    task automatic pack_send(input logic [7:0] d[$], input logic [3:0] t, input bit deliver);
        int i = 0;
        while (i < d.size()) begin
            int n = (d.size() - i) > 4 ? 4 : d.size() - i;
            logic [31:0] w;
            if (n == 4 && ((d[i+1] == 8'h80 && d[i+2] == 8'h80 && d[i+3] == 8'h80) ||
                           (d[i+2] == 8'h81 && d[i+3] == 8'h81) || d[i+3] == 8'h82))
                n = 3;
            case (n)
                1: w = {24'h808080, d[i]};
                2: w = {16'h8181, d[i+1], d[i]};
                3: w = {8'h82, d[i+2], d[i+1], d[i]};
                default: w = {d[i+3], d[i+2], d[i+1], d[i]};
            endcase
            if (deliver)
                for (int k = 0; k < n; k++) begin
                    exp_b.push_back(d[i+k]); exp_t.push_back(t);
                    exp_l.push_back(k == n-1);
                end
            push_word(w, t);
            i += n;
        end
    endtask

    task automatic compare(input string rq);
        repeat (30) @(negedge clk);
        check({rq, " byte count"}, got_b.size(), exp_b.size());
        if (got_b.size() == exp_b.size())
            for (int k = 0; k < exp_b.size(); k++) begin
                check({rq, " byte"}, got_b[k], exp_b[k]);
                check({rq, " tag R6"}, got_t[k], exp_t[k]);
                check({rq, " last R6"}, got_l[k], exp_l[k]);
            end
        exp_b.delete(); exp_t.delete(); exp_l.delete();
        got_b.delete(); got_t.delete(); got_l.delete();
    endtask

    task automatic t_reset_r10();
        @(negedge clk); #1;
        check("R10 out_valid", out_valid, 0);
        check("R10 in_ready", in_ready, 1);
    endtask

    task automatic t_one_r1();
        pack_send('{8'h41}, 4'd1, 1);
        pack_send('{8'h41, 8'h80, 8'h80, 8'h80}, 4'd1, 1);
        compare("R1");
    endtask

    task automatic t_two_r2();
        pack_send('{8'h10, 8'h20}, 4'd2, 1);
        pack_send('{8'h01, 8'h02, 8'h81, 8'h81}, 4'd2, 1);
        compare("R2");
    endtask

    task automatic t_three_r3();
        pack_send('{8'haa, 8'hbb, 8'hcc}, 4'd3, 1);
        pack_send('{8'h05, 8'h06, 8'h07, 8'h82}, 4'd3, 1);
        compare("R3");
    endtask

    task automatic t_four_r4();
        pack_send('{8'hde, 8'had, 8'hbe, 8'hef}, 4'd4, 1);
        pack_send('{8'h80, 8'h80, 8'h80, 8'h41}, 4'd4, 1);
        pack_send('{8'h81, 8'h81, 8'h82, 8'h00}, 4'd4, 1);
        compare("R4");
    endtask

    task automatic t_stream_r5();
        rdy_mode = 1;
        pack_send('{8'h48, 8'h65, 8'h6c, 8'h6c, 8'h6f, 8'h0a, 8'h80, 8'h80,
                    8'h80, 8'h7f, 8'h81, 8'h81, 8'h00, 8'hff}, 4'd9, 1);
        compare("R5 R11");
        rdy_mode = 0;
    endtask

    task automatic t_filter_r7();
        filt_en = 1'b1; filt_chan = 4'd3;
        pack_send('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 4'd5, 0);
        pack_send('{8'h66, 8'h77}, 4'd3, 1);
        pack_send('{8'h99}, 4'd12, 0);
        compare("R7");
        filt_en = 1'b0;
    endtask

    task automatic t_nofilter_r8();
        filt_chan = 4'd3;
        pack_send('{8'h01, 8'h02, 8'h03}, 4'd0, 1);
        pack_send('{8'h04}, 4'd15, 1);
        pack_send('{8'h05, 8'h06, 8'h07, 8'h08}, 4'd3, 1);
        compare("R8");
    endtask

    task automatic t_hold_r9();
        logic [7:0] b0;
        rdy_mode = 2;
        pack_send('{8'hc1, 8'hc2, 8'hc3, 8'hc4}, 4'd7, 1);
        @(negedge clk); #1;
        check("R9 first byte valid", out_valid, 1);
        check("R9 in_ready low", in_ready, 0);
        check("R9 first byte", out_byte, 8'hc1);
        b0 = out_byte;
        repeat (3) @(negedge clk);
        #1;
        check("R11 byte held", out_byte, b0);
        check("R11 valid held", out_valid, 1);
        check("R9 in_ready still low", in_ready, 0);
        rdy_mode = 0;
        compare("R9");
        check("R9 in_ready after last", in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r10();
        t_one_r1();
        t_two_r2();
        t_three_r3();
        t_four_r4();
        t_stream_r5();
        t_filter_r7();
        t_nofilter_r8();
        t_hold_r9();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule